// File: doc/BRIEF.md
# DMA Channel Register Bank and Request Checker

This block holds the programming state of a set of DMA channels and turns device-side transfer requests into burst descriptors for a separate data mover. Software programs each channel through a 32-bit register port: a mode word, a flags word that carries the enable and direction bits plus three status flags, a remaining byte count and a start address. A small number of the channels have a device request port. Through it a device asks for a transfer with a direction and a length.

The block serves one request at a time, taking the lowest-numbered pending port first. It checks the request against the channel's flags. A disabled channel or a direction mismatch is refused: the block raises a memory-error flag and a sticky per-channel bit in an interrupt-source word. A good request gets a burst descriptor whose length is the smaller of the requested length and the remaining count. When the mover acknowledges the burst, the count is reduced and the terminal-count flag is set. The address word is never advanced, so software must reprogram it between bursts. Address translation and the data movement itself happen outside the block.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every channel word and the interrupt-source word read as zero, `bst_valid` is low and `req_done` is zero.
- R2: Channel c occupies byte offsets 0x100+0x20*c to 0x11F+0x20*c. Address bits [4:3] pick the word: 0 mode, 1 flags, 2 count, 3 address. Address bits [2:0] are ignored. A written word reads back unchanged, and reads outside the map return zero.
- R3: The interrupt-source word at 0x200 holds bit c for channel c. Bus writes to it have no effect.
- R4: Only one request is handled at a time. When several ports are pending, the lowest-numbered port is served first. Request port p serves channel p.
- R5: In the flags word, bit 0 is enable, bit 1 is memory-to-device and bits 8, 9 and 10 are terminal-count, memory-error and address-error. A request on a disabled channel, or one whose `req_to_dev` differs from bit 1, clears bits 8 and 10, sets bit 9 and sets bit p of the interrupt-source word. It issues no burst and signals `req_done` together with `req_fault`.
- R6: An accepted request presents `bst_valid` with `bst_addr` equal to the channel's address word, `bst_len` equal to the smaller of the requested length and the count word, and `bst_chan` equal to p. These are held stable until `bst_ack`.
- R7: On `bst_ack`, flag bit 8 is set, the count word drops by `bst_len`, the address word is unchanged, and `req_done` is signalled without `req_fault`.
- R8: Flag bits 8, 9 and 10 are cleared in the cycle a request is accepted, so they read as zero while its burst is outstanding.
- R9: Interrupt-source bits stay set until reset.
- R10: When a bus write and a request update hit the same word in the same cycle, the request update is kept.
- R11: `bst_valid` rises one cycle after acceptance. `req_done` is high for exactly one cycle, either one cycle after a refusal or one cycle after `bst_ack`. No request is accepted while `req_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | input | NUM_REQ | Request pending, one bit per port; held until `req_done` |
| req_to_dev | input | NUM_REQ | Requested direction per port: 1 memory-to-device |
| req_len | input | NUM_REQ*32 | Requested byte length per port, port p in bits [32p+31:32p] |
| req_done | output | NUM_REQ | One-cycle completion pulse for the served port |
| req_fault | output | 1 | High with `req_done` when the request was refused |
| bst_valid | output | 1 | Burst descriptor valid |
| bst_chan | output | clog2(NUM_REQ) | Channel of the burst |
| bst_addr | output | 32 | Burst start address |
| bst_len | output | 32 | Burst length in bytes |
| bst_ack | input | 1 | Data mover accepts and completes the burst |

## Verification
The hardest case to reach is a bus write that lands in the same clock edge as the request engine's own update of a flags or count word. It can only happen at acceptance or at the acknowledge edge. The stimulus drives the register write in the same half-cycle as raising `req_valid`, and again in the same half-cycle as `bst_ack`. It then reads both words back. The arbitration order is reached by raising two request ports together and following both bursts to their end.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DW = 32;

    localparam logic [1:0] WORD_MODE  = 2'd0;
    localparam logic [1:0] WORD_FLAGS = 2'd1;
    localparam logic [1:0] WORD_COUNT = 2'd2;
    localparam logic [1:0] WORD_ADDR  = 2'd3;

    localparam int FLG_EN     = 0;
    localparam int FLG_TO_DEV = 1;
    localparam int FLG_TC     = 8;
    localparam int FLG_MERR   = 9;
    localparam int FLG_AERR   = 10;

    localparam logic [DW-1:0] STATUS_MASK =
        (DW'(1) << FLG_TC) | (DW'(1) << FLG_MERR) | (DW'(1) << FLG_AERR);

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_BURST = 2'd1,
        ENG_DONE  = 2'd2
    } eng_state_e;

    // update from the request engine into one channel's words
    typedef struct packed {
        logic          flags_we;
        logic [DW-1:0] flags_d;
        logic          count_we;
        logic [DW-1:0] count_d;
    } upd_t;

    function automatic logic [DW-1:0] clr_status(input logic [DW-1:0] f);
        return f & ~STATUS_MASK;
    endfunction

    function automatic logic [DW-1:0] min_len(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dmac_chan_set.sv
module dmac_chan_set
    import dmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [1:0]           bus_word,
    input  logic [DW-1:0]        bus_wdata,
    input  upd_t                 upd,
    output logic [3:0][DW-1:0]   words_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            if (bus_we && bus_word == WORD_MODE)
                words_q[WORD_MODE] <= bus_wdata;
            if (bus_we && bus_word == WORD_ADDR)
                words_q[WORD_ADDR] <= bus_wdata;
            // engine update wins over a same-cycle bus write
            if (upd.flags_we)
                words_q[WORD_FLAGS] <= upd.flags_d;
            else if (bus_we && bus_word == WORD_FLAGS)
                words_q[WORD_FLAGS] <= bus_wdata;
            if (upd.count_we)
                words_q[WORD_COUNT] <= upd.count_d;
            else if (bus_we && bus_word == WORD_COUNT)
                words_q[WORD_COUNT] <= bus_wdata;
        end
    end

endmodule

// File: rtl/dmac_req_engine.sv
module dmac_req_engine
    import dmac_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [NUM_REQ-1:0]          req_to_dev,
    input  logic [NUM_REQ*DW-1:0]       req_len,
    input  logic [DW-1:0]               ch_flags,
    input  logic [DW-1:0]               ch_count,
    input  logic [DW-1:0]               ch_addr,
    input  logic                        bst_ack,
    output logic [$clog2(NUM_REQ)-1:0]  eng_idx,
    output upd_t                        upd,
    output logic [NUM_REQ-1:0]          irq_set,
    output logic [NUM_REQ-1:0]          req_done,
    output logic                        req_fault,
    output logic                        bst_valid,
    output logic [DW-1:0]               bst_addr,
    output logic [DW-1:0]               bst_len
);

    localparam int IDX_W = $clog2(NUM_REQ);

    eng_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  pick;
    logic              any_req;
    logic              refuse;
    logic              accept;
    logic [DW-1:0]     len_sel;

    // fixed priority: lowest port number wins
    always_comb begin
        pick = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--)
            if (req_valid[i]) pick = IDX_W'(i);
    end

    assign any_req = |req_valid;
    assign accept  = (state_q == ENG_IDLE) && any_req;
    assign eng_idx = (state_q == ENG_IDLE) ? pick : idx_q;
    assign len_sel = req_len[int'(pick)*DW +: DW];
    assign refuse  = !ch_flags[FLG_EN] ||
                     (req_to_dev[pick] != ch_flags[FLG_TO_DEV]);

    always_comb begin
        upd     = '0;
        irq_set = '0;
        if (accept) begin
            upd.flags_we = 1'b1;
            upd.flags_d  = clr_status(ch_flags) |
                           (refuse ? (DW'(1) << FLG_MERR) : '0);
            if (refuse) irq_set = NUM_REQ'(1) << pick;
        end else if (state_q == ENG_BURST && bst_ack) begin
            upd.flags_we = 1'b1;
            upd.flags_d  = ch_flags | (DW'(1) << FLG_TC);
            upd.count_we = 1'b1;
            upd.count_d  = ch_count - bst_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            idx_q     <= '0;
            req_done  <= '0;
            req_fault <= 1'b0;
            bst_addr  <= '0;
            bst_len   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: if (any_req) begin
                    idx_q <= pick;
                    if (refuse) begin
                        state_q   <= ENG_DONE;
                        req_done  <= NUM_REQ'(1) << pick;
                        req_fault <= 1'b1;
                    end else begin
                        state_q  <= ENG_BURST;
                        bst_addr <= ch_addr;
                        bst_len  <= min_len(len_sel, ch_count);
                    end
                end
                ENG_BURST: if (bst_ack) begin
                    state_q  <= ENG_DONE;
                    req_done <= NUM_REQ'(1) << idx_q;
                end
                default: begin
                    state_q   <= ENG_IDLE;
                    req_done  <= '0;
                    req_fault <= 1'b0;
                end
            endcase
        end
    end

    assign bst_valid = (state_q == ENG_BURST);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int NUM_REQ  = 4,
    parameter int ADDR_W   = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [NUM_REQ-1:0]          req_to_dev,
    input  logic [NUM_REQ*DW-1:0]       req_len,
    output logic [NUM_REQ-1:0]          req_done,
    output logic                        req_fault,
    output logic                        bst_valid,
    output logic [$clog2(NUM_REQ)-1:0]  bst_chan,
    output logic [DW-1:0]               bst_addr,
    output logic [DW-1:0]               bst_len,
    input  logic                        bst_ack
);

    localparam int CHAN_W  = $clog2(NUM_CHAN);
    localparam int IDX_W   = $clog2(NUM_REQ);
    localparam int STRIDE_SH = 5;
    localparam logic [ADDR_W-1:0] BANK_LO  = ADDR_W'(256);
    localparam logic [ADDR_W-1:0] BANK_HI  = ADDR_W'(256 + NUM_CHAN * (1 << STRIDE_SH));
    localparam logic [ADDR_W-1:0] IRQ_ADDR = ADDR_W'(512);

    logic [ADDR_W-1:0]   bank_off;
    logic                in_bank;
    logic                is_irq;
    logic [CHAN_W-1:0]   dec_chan;
    logic [1:0]          dec_word;
    logic [CHAN_W-1:0]   eng_chan;
    logic [IDX_W-1:0]    eng_idx;
    upd_t                upd;
    logic [NUM_REQ-1:0]  irq_set;
    logic [NUM_CHAN-1:0] irq_q;
    logic [3:0][DW-1:0]  ch_words [NUM_CHAN];
    logic                unused_addr_bits;

    assign bank_off = reg_addr - BANK_LO;
    assign in_bank  = (reg_addr >= BANK_LO) && (reg_addr < BANK_HI);
    assign is_irq   = (reg_addr[ADDR_W-1:3] == IRQ_ADDR[ADDR_W-1:3]);
    assign dec_chan = bank_off[STRIDE_SH +: CHAN_W];
    assign dec_word = bank_off[4:3];
    assign unused_addr_bits = ^{bank_off[2:0], bank_off[ADDR_W-1:STRIDE_SH+CHAN_W],
                                reg_addr[2:0]};
    assign eng_chan = CHAN_W'(eng_idx);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        upd_t ch_upd;
        assign ch_upd = (eng_chan == CHAN_W'(c)) ? upd : '0;
        dmac_chan_set i_set (
            .clk       (clk),
            .rst       (rst),
            .bus_we    (reg_wr && in_bank && dec_chan == CHAN_W'(c)),
            .bus_word  (dec_word),
            .bus_wdata (reg_wdata),
            .upd       (ch_upd),
            .words_q   (ch_words[c])
        );
    end

    dmac_req_engine #(.NUM_REQ(NUM_REQ)) i_eng (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_to_dev (req_to_dev),
        .req_len    (req_len),
        .ch_flags   (ch_words[eng_chan][WORD_FLAGS]),
        .ch_count   (ch_words[eng_chan][WORD_COUNT]),
        .ch_addr    (ch_words[eng_chan][WORD_ADDR]),
        .bst_ack    (bst_ack),
        .eng_idx    (eng_idx),
        .upd        (upd),
        .irq_set    (irq_set),
        .req_done   (req_done),
        .req_fault  (req_fault),
        .bst_valid  (bst_valid),
        .bst_addr   (bst_addr),
        .bst_len    (bst_len)
    );

    assign bst_chan = eng_idx;

    // sticky interrupt sources; not writable from the bus
    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_q | NUM_CHAN'(irq_set);
    end

    always_comb begin
        if (in_bank)     reg_rdata = ch_words[dec_chan][dec_word];
        else if (is_irq) reg_rdata = DW'(irq_q);
        else             reg_rdata = '0;
    end

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk
    import dmac_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int NUM_REQ  = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_REQ-1:0]  req_done,
    input logic                req_fault,
    input logic                bst_valid,
    input logic                bst_ack,
    input logic [DW-1:0]       bst_addr,
    input logic [DW-1:0]       bst_len,
    input logic [NUM_CHAN-1:0] irq_q
);

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_done)); // R4

    AST_FAULT_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        req_fault |-> !bst_valid && (|req_done)); // R5

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (rst)
        bst_valid && !bst_ack |=> bst_valid && $stable(bst_addr) && $stable(bst_len)); // R6

    AST_ACK_DONE: assert property (@(posedge clk) disable iff (rst)
        bst_valid && bst_ack |=> (|req_done) && !req_fault && !bst_valid); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q & ~$past(irq_q)) == irq_q || ($past(irq_q) & ~irq_q) == '0); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|req_done) |=> !(|req_done) && !bst_valid); // R11

endmodule

bind dma_chan_ctrl dmac_chk #(.NUM_CHAN(NUM_CHAN), .NUM_REQ(NUM_REQ)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_done  (req_done),
    .req_fault (req_fault),
    .bst_valid (bst_valid),
    .bst_ack   (bst_ack),
    .bst_addr  (bst_addr),
    .bst_len   (bst_len),
    .irq_q     (irq_q)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [9:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NREQ-1:0]   req_valid = '0;
    logic [NREQ-1:0]   req_to_dev = '0;
    logic [NREQ*32-1:0] req_len = '0;
    logic [NREQ-1:0]   req_done;
    logic              req_fault;
    logic              bst_valid;
    logic [1:0]        bst_chan;
    logic [31:0]       bst_addr;
    logic [31:0]       bst_len;
    logic              bst_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_to_dev(req_to_dev), .req_len(req_len), .req_done(req_done),
        .req_fault(req_fault), .bst_valid(bst_valid), .bst_chan(bst_chan),
        .bst_addr(bst_addr), .bst_len(bst_len), .bst_ack(bst_ack)
    );

    typedef struct packed {
        logic [9:0]  wa;
        logic [31:0] wd;
        logic [9:0]  ra;
        logic [31:0] exp;
    } vec_t;

    // R2 map / R3 read-only source word
    localparam vec_t VEC [8] = '{
        '{10'h100, 32'h0000_00A5, 10'h100, 32'h0000_00A5},
        '{10'h110, 32'h0000_1234, 10'h114, 32'h0000_1234},
        '{10'h1F8, 32'hDEAD_BEEF, 10'h1F8, 32'hDEAD_BEEF},
        '{10'h1E0, 32'h0000_0055, 10'h1E8, 32'h0000_0000},
        '{10'h123, 32'h0000_0077, 10'h120, 32'h0000_0077},
        '{10'h200, 32'h0000_00FF, 10'h200, 32'h0000_0000},
        '{10'h240, 32'h0000_0011, 10'h240, 32'h0000_0000},
        '{10'h0F8, 32'h0000_0022, 10'h0F8, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // request on port p; caller is just after a falling edge
    task automatic run_req(input int p, input logic dir, input logic [31:0] len,
                           input logic exp_fault, input logic [31:0] exp_addr,
                           input logic [31:0] exp_len, input string tag);
        logic [31:0] v;
        req_valid[p] = 1'b1; req_to_dev[p] = dir; req_len[p*32 +: 32] = len;
        @(negedge clk);
        if (exp_fault) begin
            chk({tag, " R5 refused done"}, 32'(req_done), 32'(1 << p));
            chk({tag, " R5 fault flag"}, 32'(req_fault), 32'd1);
            chk({tag, " R5 no burst"}, 32'(bst_valid), 32'd0);
        end else begin
            chk({tag, " R11 burst valid"}, 32'(bst_valid), 32'd1);
            chk({tag, " R6 addr"}, bst_addr, exp_addr);
            chk({tag, " R6 len"}, bst_len, exp_len);
            chk({tag, " R4 chan"}, 32'(bst_chan), 32'(p));
            rd(10'(32'h108 + p * 32'h20), v);
            chk({tag, " R8 flags cleared"}, v & 32'h700, 32'h0);
            bst_ack = 1'b1;
            @(negedge clk);
            bst_ack = 1'b0;
            chk({tag, " R7 done"}, 32'(req_done), 32'(1 << p));
            chk({tag, " R7 no fault"}, 32'(req_fault), 32'd0);
        end
        req_valid[p] = 1'b0;
        @(negedge clk);
        chk({tag, " R11 done one cycle"}, 32'(req_done), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired got 0 exp 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(10'h108, v); chk("R1 ch0 flags", v, 0);
        rd(10'h1F8, v); chk("R1 ch7 addr", v, 0);
        rd(10'h200, v); chk("R1 irq word", v, 0);
        chk("R1 no burst", 32'(bst_valid), 0);
        chk("R1 no done", 32'(req_done), 0);

        // R2 / R3 vector table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, v);
            chk($sformatf("R2 vector %0d", i), v, VEC[i].exp);
        end

        // ch0 valid, stale status bits present
        wr(10'h108, 32'h701); wr(10'h110, 100); wr(10'h118, 32'h8000_1000);
        run_req(0, 1'b0, 40, 1'b0, 32'h8000_1000, 40, "ch0 a");
        rd(10'h108, v); chk("R7 ch0 flags tc", v, 32'h101);
        rd(10'h110, v); chk("R7 ch0 count", v, 60);
        rd(10'h118, v); chk("R7 ch0 addr kept", v, 32'h8000_1000);

        // R6 clamp to remaining count
        run_req(0, 1'b0, 100, 1'b0, 32'h8000_1000, 60, "ch0 clamp");
        rd(10'h110, v); chk("R6 ch0 count zero", v, 0);

        // R5 direction mismatch
        run_req(0, 1'b1, 8, 1'b1, 0, 0, "ch0 dir");
        rd(10'h108, v); chk("R5 ch0 merr", v, 32'h201);
        rd(10'h200, v); chk("R5 irq bit0", v, 32'h01);

        // R5 disabled channel
        wr(10'h168, 32'h102);
        run_req(3, 1'b1, 8, 1'b1, 0, 0, "ch3 off");
        rd(10'h168, v); chk("R5 ch3 merr", v, 32'h202);
        rd(10'h200, v); chk("R5 irq bit3", v, 32'h09);

        // R4 priority between two pending ports
        wr(10'h128, 32'h001); wr(10'h130, 8);  wr(10'h138, 32'h1000);
        wr(10'h148, 32'h003); wr(10'h150, 16); wr(10'h158, 32'h2000);
        req_to_dev[1] = 1'b0; req_len[32 +: 32] = 4;
        req_to_dev[2] = 1'b1; req_len[64 +: 32] = 32;
        req_valid[1] = 1'b1; req_valid[2] = 1'b1;
        @(negedge clk);
        chk("R4 first chan", 32'(bst_chan), 1);
        chk("R6 first len", bst_len, 4);
        bst_ack = 1'b1;
        @(negedge clk);
        bst_ack = 1'b0;
        chk("R4 first done", 32'(req_done), 32'h2);
        req_valid[1] = 1'b0;
        @(negedge clk);
        chk("R11 idle gap", 32'(bst_valid), 0);
        @(negedge clk);
        chk("R4 second chan", 32'(bst_chan), 2);
        chk("R6 second len", bst_len, 16);
        chk("R6 second addr", bst_addr, 32'h2000);
        bst_ack = 1'b1;
        @(negedge clk);
        bst_ack = 1'b0;
        chk("R4 second done", 32'(req_done), 32'h4);
        req_valid[2] = 1'b0;
        @(negedge clk);
        rd(10'h130, v); chk("R7 ch1 count", v, 4);
        rd(10'h150, v); chk("R7 ch2 count", v, 0);
        rd(10'h148, v); chk("R7 ch2 flags", v, 32'h103);

        // R10 same-cycle bus write at acceptance and at acknowledge
        req_to_dev[1] = 1'b0; req_len[32 +: 32] = 2; req_valid[1] = 1'b1;
        reg_wr = 1'b1; reg_addr = 10'h128; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R10 burst despite write", 32'(bst_valid), 1);
        rd(10'h128, v); chk("R10 flags engine wins", v, 32'h001);
        bst_ack = 1'b1;
        reg_wr = 1'b1; reg_addr = 10'h130; reg_wdata = 32'h999;
        @(negedge clk);
        bst_ack = 1'b0; reg_wr = 1'b0; req_valid[1] = 1'b0;
        @(negedge clk);
        rd(10'h130, v); chk("R10 count engine wins", v, 2);
        rd(10'h128, v); chk("R10 flags after ack", v, 32'h101);
        rd(10'h138, v); chk("R7 ch1 addr kept", v, 32'h1000);

        // R9 / R3 sticky, not writable
        wr(10'h200, 32'h0);
        rd(10'h200, v); chk("R9 irq sticky", v, 32'h09);

        // R1 / R9 reset clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(10'h200, v); chk("R9 irq cleared by reset", v, 0);
        rd(10'h128, v); chk("R1 ch1 flags after reset", v, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule